// File: doc/BRIEF.md
# BCD Time-of-Day Calendar with Frozen Host View

This block keeps the time of day and the date as BCD fields: seconds, minutes, hours, date, month, a two-digit year and a day-of-week. A single-cycle enable pulse, once per second, advances a set of internal counters. The ripple runs from seconds up to the year. Month lengths follow the calendar, and February takes a leap-year correction.

The host never touches the counters directly. It reads and writes a separate bank of visible registers through a parallel register port with an address, a write strobe, a read strobe and an 8-bit data bus. After every advance the bank is refreshed from the counters in one step. Hours are shown in either 12-hour form, with a PM flag in bit 7, or in 24-hour form. A control bit, the inhibit, freezes the bank. While it is set, the host can read a coherent snapshot or write new values, and the counters keep running underneath. Clearing the inhibit copies every register the host wrote during the freeze into its counter. Counters that were not written are left as they are.

Register map (each address holds one byte):
- 0: seconds
- 1: minutes
- 2: hours
- 3: date
- 4: month
- 5: year
- 6: day-of-week
- 7: control. Bit 3 is the inhibit. Bit 1 selects 24-hour mode when set.
- 8 to 15: unused.

Top module: `rtc_shadow_cal`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x12 (12-hour mode, midnight), date 0x01, month 0x01, year 0x00, day-of-week 0x01 and control 0x00. Every counter holds a valid BCD value in its range: seconds and minutes 00–59, internal hour 00–23, date 01–31, month 01–12, year 00–99, day-of-week 1–7.
- R2: Each tick advances the seconds by one. A wrap to 00 carries into minutes, then into hours (wrap at 23), date, month (wrap 12 to 01) and year (wrap 99 to 00).
- R3: The date wraps to 01 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. In month 2 it wraps after day 29 when the two-digit year is a multiple of 4, and after day 28 otherwise.
- R4: The day-of-week steps by one on every date change and wraps from 7 to 1. Sunday is coded as 1.
- R5: A tick sampled at clock edge E updates the visible registers at edge E+1, but only while the inhibit (control bit 3) is 0. While the inhibit is 1 the visible registers do not change except through host writes, and the counters keep advancing.
- R6: A refresh already under way completes. If the inhibit is written to 1 at edge E+1 after a tick at E, the visible registers still take the advanced values at that edge, and later ticks leave them frozen.
- R7: Writing the inhibit from 1 to 0 loads into its counter every time register that was written while inhibited. Counters that were not written keep their running value. The visible bank is not changed by that write, and refreshes resume with the next tick.
- R8: Host writes to time registers (addresses 0–6) while the inhibit is 0 are ignored. The visible register and its counter both keep their values.
- R9: With control bit 1 at 0, the hour reads 0x12 at internal hour 0, 0x01–0x11 for 1–11, 0x92 for 12, and 0x81–0x91 for 13–23. With control bit 1 at 1, it reads 0x00–0x23. A written hour is decoded under the mode in force when the transfer happens.
- R10: Unused bits cannot be written and read as 0. The write masks are seconds 0x7F, minutes 0x7F, hours 0xBF, date 0x3F, month 0x1F, year 0xFF, day-of-week 0x07 and control 0x0A. Addresses 8–15 read 0x00.
- R11: When the read strobe is low the data output is 0x00. Reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second, that advances the counters |
| addr | input | ADDR_W (4) | Register address |
| wr_en | input | 1 | Write strobe; data is taken at the clock edge |
| rd_en | input | 1 | Read strobe; gates the data output |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the address |

## Verification
The bench builds the block with its default 4-bit address, so every one of the 16 addresses is reachable, including the unused upper half.

The calendar boundaries would take years of ticks to reach by counting alone. The bench reaches them through the freeze-and-transfer path instead: it loads a time such as a year end, a leap February or a 30-day month end, then ticks across the boundary. That same path covers these cases:
- partial transfers, where only some registers are written;
- hour decoding in both modes;
- a freeze issued one cycle after a tick.

Random loads placed near carry points cover the carry chain across many starting values.

// File: rtl/rtc_cal_pkg.sv
// Package: shared field indices, control bit positions and BCD helpers for
// the shadowed calendar. Assumes 8-bit BCD fields throughout.
package rtc_cal_pkg;

    localparam int NUM_TIME  = 7;
    localparam int DATA_W    = 8;
    localparam int F_SEC     = 0;
    localparam int F_MIN     = 1;
    localparam int F_HOUR    = 2;
    localparam int F_DATE    = 3;
    localparam int F_MON     = 4;
    localparam int F_YEAR    = 5;
    localparam int F_DOW     = 6;
    localparam int CTRL_ADDR = NUM_TIME;
    localparam int CTRL_INH  = 3;
    localparam int CTRL_H24  = 1;

    typedef logic [DATA_W-1:0] bcd8_t;
    typedef logic [NUM_TIME-1:0][DATA_W-1:0] time_vec_t;

    // Advance a two-digit BCD value by one (no wrap handling).
    function automatic bcd8_t bcd_inc(bcd8_t v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD to binary for values up to 99.
    function automatic logic [6:0] bcd2bin(bcd8_t v);
        return 7'(7'(v[7:4]) * 7'd10 + 7'(v[3:0]));
    endfunction

    // Binary to BCD for values up to 99.
    function automatic bcd8_t bin2bcd(logic [6:0] b);
        return {4'(b / 7'd10), 4'(b % 7'd10)};
    endfunction

    // Last valid date of a month; the leap test is year mod 4 on BCD digits.
    function automatic bcd8_t month_days(bcd8_t mon, bcd8_t yr);
        logic [3:0] low2;
        low2 = yr[3:0] + {2'b00, yr[4], 1'b0};
        case (mon)
            8'h02:   return (low2[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default: return 8'h31;
        endcase
    endfunction

    // Internal 24-hour BCD hour to its visible encoding.
    function automatic bcd8_t hour_to_vis(bcd8_t h, logic m24);
        logic [6:0] b;
        b = bcd2bin(h);
        if (m24)        return h;
        if (b == 7'd0)  return 8'h12;
        if (b < 7'd12)  return h;
        if (b == 7'd12) return 8'h92;
        return 8'h80 | bin2bcd(b - 7'd12);
    endfunction

    // Visible hour encoding back to the internal 24-hour BCD hour.
    function automatic bcd8_t hour_from_vis(bcd8_t v, logic m24);
        logic [6:0] b;
        if (m24) return {2'b00, v[5:0]};
        b = bcd2bin({3'b000, v[4:0]});
        if (b == 7'd12) b = 7'd0;
        if (v[7])       b = b + 7'd12;
        return bin2bcd(b);
    endfunction

    // Writable bits of each time field.
    function automatic bcd8_t field_mask(int idx);
        case (idx)
            F_SEC, F_MIN: return 8'h7F;
            F_HOUR:       return 8'hBF;
            F_DATE:       return 8'h3F;
            F_MON:        return 8'h1F;
            F_DOW:        return 8'h07;
            default:      return 8'hFF;
        endcase
    endfunction

    // Lowest value (and reset value) of each counter.
    function automatic bcd8_t field_min(int idx);
        return (idx == F_DATE || idx == F_MON || idx == F_DOW) ? 8'h01 : 8'h00;
    endfunction

    // Fixed wrap point of each counter; the date's limit is computed at run time.
    function automatic bcd8_t field_max(int idx);
        case (idx)
            F_SEC, F_MIN: return 8'h59;
            F_HOUR:       return 8'h23;
            F_MON:        return 8'h12;
            F_DOW:        return 8'h07;
            F_DATE:       return 8'h31;
            default:      return 8'h99;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_ctr.sv
// Module: one two-digit BCD counter with a run-time wrap limit and a
// parallel load. Assumes its value stays valid BCD between MIN_VAL and hi.
module rtc_bcd_ctr #(
    parameter int                W       = 8,
    parameter logic [W-1:0]      MIN_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] hi,
    output logic [W-1:0] q,
    output logic         at_max
);
    import rtc_cal_pkg::*;

    // Count register: load has priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= MIN_VAL;
        else if (load)   q <= load_val;
        else if (en)     q <= (q == hi) ? MIN_VAL : W'(bcd_inc(8'(q)));
    end

    assign at_max = (q == hi);

endmodule

// File: rtl/rtc_cal_counters.sv
// Module: internal time counters in 24-hour BCD with the carry ripple from
// seconds to year, plus the day-of-week. A tick that lands on a transfer
// cycle is held and applied one cycle later to the loaded values.
module rtc_cal_counters
    import rtc_cal_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                xfer,
    input  logic [NUM_TIME-1:0] load_mask,
    input  time_vec_t           load_vals,
    output time_vec_t           cnt,
    output logic                adv_q,
    output logic                tick_held
);
    localparam int CHAIN_LEN = F_YEAR + 1;

    logic                tick_go;
    logic [NUM_TIME-1:0] en;
    logic [NUM_TIME-1:0] at_max;
    time_vec_t           hi;

    assign tick_go = (tick || tick_held) && !xfer;

    // Carry ripple from seconds up to the year; day-of-week follows the date.
    always_comb begin
        logic c;
        logic day_en;
        c      = tick_go;
        day_en = 1'b0;
        en     = '0;
        for (int i = 0; i < CHAIN_LEN; i++) begin
            en[i] = c;
            if (i == F_DATE) day_en = c;
            c = c && at_max[i];
        end
        en[F_DOW] = day_en;
    end

    // Wrap limit per field; the date's limit depends on month and year.
    always_comb begin
        for (int i = 0; i < NUM_TIME; i++) hi[i] = field_max(i);
        hi[F_DATE] = month_days(cnt[F_MON], cnt[F_YEAR]);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_TIME; g++) begin : g_field
            rtc_bcd_ctr #(
                .W       (DATA_W),
                .MIN_VAL (field_min(g))
            ) u_ctr (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (en[g]),
                .load     (load_mask[g]),
                .load_val (load_vals[g]),
                .hi       (hi[g]),
                .q        (cnt[g]),
                .at_max   (at_max[g])
            );
        end
    endgenerate

    // Advance marker for the refresh and deferral of a colliding tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q     <= 1'b0;
            tick_held <= 1'b0;
        end else begin
            adv_q     <= tick_go;
            tick_held <= (tick || tick_held) && xfer;
        end
    end

endmodule

// File: rtl/rtc_cal_regbank.sv
// Module: host-visible register bank with the control byte, per-register
// dirty bits and the 12/24-hour conversion on both copy directions.
// Assumes the host writes valid BCD while the inhibit is set.
module rtc_cal_regbank
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  time_vec_t           cnt,
    input  logic                refresh,
    output time_vec_t           vis,
    output logic                inhibit,
    output logic                mode24,
    output logic                xfer,
    output logic [NUM_TIME-1:0] load_mask,
    output time_vec_t           load_vals
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic                wr_ctrl;
    logic [NUM_TIME-1:0] wr_time;
    logic [NUM_TIME-1:0] dirty;

    // Write decode: time writes only count while the bank is frozen.
    always_comb begin
        wr_ctrl = wr_en && (addr == CTRL_A);
        for (int i = 0; i < NUM_TIME; i++)
            wr_time[i] = wr_en && (addr == ADDR_W'(i)) && inhibit;
    end

    assign xfer = wr_ctrl && !wdata[CTRL_INH] && inhibit;

    // Control byte: inhibit and hour-mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inhibit <= 1'b0;
            mode24  <= 1'b0;
        end else if (wr_ctrl) begin
            inhibit <= wdata[CTRL_INH];
            mode24  <= wdata[CTRL_H24];
        end
    end

    // Visible registers: masked host writes or a refresh from the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TIME; i++) vis[i] <= field_min(i);
            vis[F_HOUR] <= hour_to_vis(8'h00, 1'b0);
        end else begin
            for (int i = 0; i < NUM_TIME; i++) begin
                if (wr_time[i])
                    vis[i] <= wdata & field_mask(i);
                else if (refresh && !inhibit)
                    vis[i] <= (i == F_HOUR) ? hour_to_vis(cnt[i], mode24) : cnt[i];
            end
        end
    end

    // Dirty bits: set by a frozen write, cleared by the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    dirty <= '0;
        else if (xfer) dirty <= '0;
        else           dirty <= dirty | wr_time;
    end

    // Transfer values: the hour is decoded back to 24-hour form.
    always_comb begin
        load_mask = xfer ? dirty : '0;
        for (int i = 0; i < NUM_TIME; i++) load_vals[i] = vis[i];
        load_vals[F_HOUR] = hour_from_vis(vis[F_HOUR], mode24);
    end

    // Read mux, gated by the read strobe.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NUM_TIME; i++)
                if (addr == ADDR_W'(i)) rdata = vis[i];
            if (addr == CTRL_A) begin
                rdata[CTRL_INH] = inhibit;
                rdata[CTRL_H24] = mode24;
            end
        end
    end

endmodule

// File: rtl/rtc_shadow_cal.sv
// Module: top of the shadowed BCD calendar. Ties the internal counters to
// the host register bank. Assumes tick_1hz is a one-cycle pulse.
module rtc_shadow_cal
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    time_vec_t           cnt;
    time_vec_t           vis;
    time_vec_t           load_vals;
    logic [NUM_TIME-1:0] load_mask;
    logic                refresh;
    logic                tick_held;
    logic                xfer;
    logic                inhibit;
    logic                mode24;

    rtc_cal_counters u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1hz),
        .xfer      (xfer),
        .load_mask (load_mask),
        .load_vals (load_vals),
        .cnt       (cnt),
        .adv_q     (refresh),
        .tick_held (tick_held)
    );

    rtc_cal_regbank #(.ADDR_W(ADDR_W)) u_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .rdata     (rdata),
        .cnt       (cnt),
        .refresh   (refresh),
        .vis       (vis),
        .inhibit   (inhibit),
        .mode24    (mode24),
        .xfer      (xfer),
        .load_mask (load_mask),
        .load_vals (load_vals)
    );

endmodule

// File: rtl/rtc_shadow_cal_chk.sv
// Module: property checker for the shadowed calendar, bound to the top.
// Assumes synchronous active-low reset; all properties are off in reset.
module rtc_shadow_cal_chk
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_1hz,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic [7:0]          rdata,
    input time_vec_t           cnt,
    input time_vec_t           vis,
    input logic                inhibit,
    input logic                mode24,
    input logic                xfer,
    input logic                refresh,
    input logic                tick_held,
    input logic [NUM_TIME-1:0] load_mask,
    input time_vec_t           load_vals
);
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[F_SEC] <= 8'h59) && (cnt[F_SEC][3:0] <= 4'd9) && (cnt[F_HOUR] <= 8'h23)
        && (cnt[F_DOW] >= 8'h01) && (cnt[F_DOW] <= 8'h07)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !tick_held && !xfer) |=> $stable(cnt)); // R2

    AST_FREEZE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !wr_en) |=> $stable(vis)); // R5

    AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && load_mask[F_MIN]) |=> (cnt[F_MIN] == $past(load_vals[F_MIN]))); // R7

    AST_XFER_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> $stable(vis)); // R7

    AST_PM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && !inhibit && !mode24) |=>
        ((vis[F_HOUR][6] == 1'b0) && (vis[F_HOUR][5:0] >= 6'h01) && (vis[F_HOUR][5:0] <= 6'h12))); // R9

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr > ADDR_W'(CTRL_ADDR))) |-> (rdata == 8'h00)); // R10

    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == 8'h00)); // R11

endmodule

bind rtc_shadow_cal rtc_shadow_cal_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .cnt       (cnt),
    .vis       (vis),
    .inhibit   (inhibit),
    .mode24    (mode24),
    .xfer      (xfer),
    .refresh   (refresh),
    .tick_held (tick_held),
    .load_mask (load_mask),
    .load_vals (load_vals)
);

// File: tb/rtc_shadow_cal_tb.sv
// Bench: directed boundary cases and seeded random loads against a
// behavioural calendar model kept in binary.
module rtc_shadow_cal_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int m_s, m_mi, m_h, m_d, m_mo, m_y, m_w;
    bit m24, minh;
    logic [7:0] v [0:6];

    rtc_shadow_cal u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] bcd(int x);
        return 8'(((x / 10) << 4) | (x % 10));
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hvis(int h, bit md24);
        if (md24) return bcd(h);
        if (h == 0) return 8'h12;
        if (h < 12) return bcd(h);
        if (h == 12) return 8'h92;
        return 8'h80 | bcd(h - 12);
    endfunction

    task automatic m_adv();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    m_w = (m_w == 7) ? 1 : m_w + 1;
                    m_d++;
                    if (m_d > dim(m_mo, m_y)) begin
                        m_d = 1; m_mo++;
                        if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic m_copy();
        v[0] = bcd(m_s); v[1] = bcd(m_mi); v[2] = hvis(m_h, m24);
        v[3] = bcd(m_d); v[4] = bcd(m_mo); v[5] = bcd(m_y); v[6] = bcd(m_w);
    endtask

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    // one tick; returns after the refresh edge has passed
    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk);
        m_adv();
        if (!minh) m_copy();
    endtask

    task automatic check_all(string req);
        logic [7:0] d;
        for (int i = 0; i < 7; i++) begin
            rd(4'(i), d);
            check8(req, $sformatf("reg %0d", i), d, v[i]);
        end
    endtask

    function automatic logic [7:0] ctrl(bit inh, bit md24);
        return {4'b0, inh, 1'b0, md24, 1'b0};
    endfunction

    // load a full time through the freeze/transfer path
    task automatic load_time(int s, int mi, int h, int d, int mo, int y, int w, bit md24);
        wr(4'd7, ctrl(1'b1, md24));
        m24 = md24; minh = 1'b1;
        wr(4'd0, bcd(s)); wr(4'd1, bcd(mi)); wr(4'd2, hvis(h, md24));
        wr(4'd3, bcd(d)); wr(4'd4, bcd(mo)); wr(4'd5, bcd(y)); wr(4'd6, bcd(w));
        wr(4'd7, ctrl(1'b0, md24));
        minh = 1'b0;
        m_s = s; m_mi = mi; m_h = h; m_d = d; m_mo = mo; m_y = y; m_w = w;
        m_copy();
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0017));
        m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_w = 1;
        m24 = 1'b0; minh = 1'b0;
        m_copy();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check_all("R1");
        rd(4'd2, d); check8("R1", "reset hour", d, 8'h12);
        rd(4'd7, d); check8("R1", "reset ctrl", d, 8'h00);

        // R11 strobe low gives zero
        addr = 4'd2; #1; check8("R11", "rd_en low", rdata, 8'h00);

        // R2 seconds advance and minute carry
        tick(); check_all("R2");
        load_time(59, 59, 10, 5, 6, 40, 3, 1'b1);
        tick(); check_all("R2");

        // R3 leap February
        load_time(59, 59, 23, 28, 2, 24, 7, 1'b1);
        tick(); check_all("R3");
        rd(4'd3, d); check8("R3", "leap date", d, 8'h29);
        rd(4'd6, d); check8("R4", "dow wrap", d, 8'h01);
        // R3 non-leap February
        load_time(59, 59, 23, 28, 2, 23, 2, 1'b1);
        tick(); check_all("R3");
        rd(4'd4, d); check8("R3", "march", d, 8'h03);
        // R3 30-day month
        load_time(59, 59, 23, 30, 4, 10, 5, 1'b1);
        tick(); check_all("R3");
        rd(4'd3, d); check8("R3", "may 1", d, 8'h01);
        // R2 year wrap
        load_time(59, 59, 23, 31, 12, 99, 6, 1'b1);
        tick(); check_all("R2");
        rd(4'd5, d); check8("R2", "year wrap", d, 8'h00);
        rd(4'd6, d); check8("R4", "dow step", d, 8'h07);

        // R9 hour encodings in 12-hour mode
        load_time(59, 59, 11, 3, 3, 5, 1, 1'b0);
        tick(); rd(4'd2, d); check8("R9", "noon", d, 8'h92);
        load_time(59, 59, 12, 3, 3, 5, 1, 1'b0);
        tick(); rd(4'd2, d); check8("R9", "1 PM", d, 8'h81);
        load_time(59, 59, 23, 3, 3, 5, 1, 1'b0);
        tick(); rd(4'd2, d); check8("R9", "midnight", d, 8'h12);
        check_all("R9");
        // R9 PM write decoded, then read in 24-hour mode
        load_time(0, 0, 15, 3, 3, 5, 1, 1'b0);
        rd(4'd2, d); check8("R9", "3 PM written", d, 8'h83);
        wr(4'd7, ctrl(1'b0, 1'b1)); m24 = 1'b1;
        tick(); rd(4'd2, d); check8("R9", "24h 15", d, 8'h15);

        // R5 freeze while counters run
        load_time(20, 10, 8, 9, 9, 9, 4, 1'b1);
        wr(4'd7, ctrl(1'b1, 1'b1)); minh = 1'b1;
        tick(); tick(); tick();
        check_all("R5");
        wr(4'd7, ctrl(1'b0, 1'b1)); minh = 1'b0;
        check_all("R5");
        tick(); check_all("R5");
        rd(4'd0, d); check8("R5", "ran during freeze", d, 8'h24);

        // R6 freeze issued while refresh in flight
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        addr = 4'd7; wdata = ctrl(1'b1, 1'b1); wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        m_adv(); m_copy(); minh = 1'b1;
        check_all("R6");
        tick(); check_all("R6");
        wr(4'd7, ctrl(1'b0, 1'b1)); minh = 1'b0;

        // R7 partial transfer: only minutes written
        load_time(10, 5, 14, 20, 7, 31, 2, 1'b1);
        wr(4'd7, ctrl(1'b1, 1'b1)); minh = 1'b1;
        tick(); tick();
        wr(4'd1, 8'h30); v[1] = 8'h30;
        wr(4'd7, ctrl(1'b0, 1'b1)); minh = 1'b0; m_mi = 30;
        rd(4'd1, d); check8("R7", "view after xfer", d, 8'h30);
        rd(4'd0, d); check8("R7", "view sec kept", d, 8'h10);
        tick(); check_all("R7");
        rd(4'd0, d); check8("R7", "sec kept running", d, 8'h13);

        // R8 writes ignored when not frozen
        wr(4'd0, 8'h45);
        rd(4'd0, d); check8("R8", "ignored write view", d, v[0]);
        tick(); check_all("R8");

        // R10 masks and unused addresses
        wr(4'd7, 8'hFF); minh = 1'b1; m24 = 1'b1;
        rd(4'd7, d); check8("R10", "ctrl mask", d, 8'h0A);
        wr(4'd6, 8'hFF); rd(4'd6, d); check8("R10", "dow mask", d, 8'h07);
        wr(4'd4, 8'hF1); rd(4'd4, d); check8("R10", "month mask", d, 8'h11);
        wr(4'd3, 8'hC1); rd(4'd3, d); check8("R10", "date mask", d, 8'h01);
        wr(4'd0, 8'h85); rd(4'd0, d); check8("R10", "sec mask", d, 8'h05);
        wr(4'd2, 8'h53); rd(4'd2, d); check8("R10", "hour mask", d, 8'h13);
        rd(4'd9, d); check8("R10", "addr 9", d, 8'h00);
        rd(4'd15, d); check8("R10", "addr 15", d, 8'h00);
        load_time(0, 0, 0, 1, 1, 0, 1, 1'b0);
        check_all("R10");

        // R2 random loads near carry points
        for (int it = 0; it < 20; it++) begin
            int s, mi, h, dd, mo, y, w, n;
            bit md;
            s  = $urandom_range(50, 59);
            mi = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 58);
            h  = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 22);
            mo = $urandom_range(1, 12);
            y  = $urandom_range(0, 99);
            dd = ($urandom_range(0, 1) == 1) ? dim(mo, y) : $urandom_range(1, 28);
            w  = $urandom_range(1, 7);
            md = 1'($urandom_range(0, 1));
            n  = $urandom_range(1, 12);
            load_time(s, mi, h, dd, mo, y, w, md);
            for (int k = 0; k < n; k++) tick();
            check_all("R2");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule